// File: doc/BRIEF.md
# Ring Media Converter Insertion Controller

This block is the digital control state machine of a copper-to-fiber ring media converter. Two static configuration straps select one of four roles. Two of these roles make the converter itself request ring insertion: one is triggered by phantom power on the copper side, and the other by sustained optical activity together with phantom power. The other two roles react to insertion and bypass keys recognised on the fiber side. One of these reactive roles also drives phantom current toward the copper lobe.

The block does not produce the key waveforms, the squelch or the phantom fault sensing. A neighbouring generator receives its one-cycle key requests. A neighbouring recognizer supplies one-cycle "insertion key seen", "bypass key seen" and "echo seen" pulses. A fault sense supplies a level. The block drives a path-select code for the signal multiplexer, a phantom drive enable and an active-low inserted indicator. All timing comes from a slow reference clock of about 32.768 kHz. A qualification span of QUAL_CYC cycles corresponds to 26.5 ms, and an echo window of ECHO_CYC cycles corresponds to 100 ms.

Top module: `ring_insert_ctrl`

## Requirements
- R1: Strap decode: strap_keygen=1 with strap_cu_gnd=0 selects the phantom-triggered role; strap_keygen=0 with strap_cu_gnd=0 selects the concentrator role; strap_keygen=0 with strap_cu_gnd=1 selects the lobe role; strap_keygen=1 with strap_cu_gnd=1 selects the ring-in role.
- R2: In the phantom-triggered role, req_ins_key pulses for one cycle on the QUAL_CYC-th consecutive clock edge at which both phan_a and phan_b are low. Either input high restarts the count.
- R3: After an insertion request in either generating role, an echo_seen pulse within ECHO_CYC edges enters the insert state and drives inserted_n low on that edge. phan_a and phan_b have no effect while the block waits for the echo.
- R4: If no echo arrives by the ECHO_CYC-th edge after the request, the block returns to idle and restarts qualification from zero. A later echo_seen is ignored.
- R5: In the insert state of a generating role, phan_a or phan_b high raises inserted_n and pulses req_byp_key on the same edge. The insertion and bypass requests never coincide.
- R6: In the ring-in role, qualification counts only edges at which opt_active=1 and both phantom inputs are low. A single edge without activity restarts the count.
- R7: In the ring-in role, the insert state is left (inserted_n high, req_byp_key pulse) after QUAL_CYC consecutive edges with opt_active=0, or on either phantom input high. A shorter gap in activity does not exit.
- R8: In the concentrator role, ins_key_seen enters insert and sets phan_drive_en. inserted_n is low there only while phan_fault=0, and follows phan_fault one edge later. byp_key_seen clears both.
- R9: In the lobe role, ins_key_seen enters insert (inserted_n low) and byp_key_seen returns to bypass. phan_drive_en stays low.
- R10: path_sel encoding: 2'b00 means copper-to-fiber plus fiber-to-copper, 2'b01 means copper-to-copper plus fiber-to-fiber, and 2'b10 means copper-to-copper plus copper-to-fiber. The phantom-triggered and concentrator roles always give 2'b00. The lobe role gives 2'b00 in insert and 2'b01 otherwise. The ring-in role gives 2'b00 in insert and 2'b10 otherwise.
- R11: While rst is high: inserted_n=1, phan_drive_en=0, path_sel=2'b00, and no request pulses. The role's bypass path appears one edge after release.
- R12: Key requests occur only in the generating roles. ins_key_seen, byp_key_seen and echo_seen outside the states that use them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow reference clock (about 32.768 kHz) |
| rst | input | 1 | Synchronous active-high reset |
| strap_keygen | input | 1 | Key-generation strap |
| strap_cu_gnd | input | 1 | Copper-ok strap grounded (1 = grounded) |
| phan_a | input | 1 | Phantom status line A (high = power absent / bypass request) |
| phan_b | input | 1 | Phantom status line B |
| opt_active | input | 1 | Qualified optical input activity |
| ins_key_seen | input | 1 | One-cycle pulse: insertion key recognised |
| byp_key_seen | input | 1 | One-cycle pulse: bypass key recognised |
| echo_seen | input | 1 | One-cycle pulse: insertion key echo recognised |
| phan_fault | input | 1 | Phantom wire fault level |
| req_ins_key | output | 1 | One-cycle request to emit an insertion key |
| req_byp_key | output | 1 | One-cycle request to emit a bypass key |
| phan_drive_en | output | 1 | Enable phantom current drive |
| inserted_n | output | 1 | Active-low inserted indicator |
| path_sel | output | 2 | Signal multiplexer routing code |

## Verification
Every cycle, the assertions check the following. The two request pulses never coincide, and insertion requests occur only in generating roles. Each rise of the indicator in a generating role comes with a bypass request. The concentrator indicator is low only with phantom drive on. Roles whose copper strap is not grounded keep the cross path, and the span counters stay in range. The exact qualification length and its restart, the echo window and its timeout, the inactivity exit and the fault gating of the indicator depend on stimulus history. Only the bench's directed scenarios, which count edges up to each boundary, can show these.

// File: rtl/ring_ctrl_pkg.sv
package ring_ctrl_pkg;

  typedef enum logic [1:0] {
    ROLE_PHANTOM = 2'd0,
    ROLE_CONC    = 2'd1,
    ROLE_LOBE    = 2'd2,
    ROLE_RINGIN  = 2'd3
  } role_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ECHO = 2'd1,
    ST_INS  = 2'd2
  } ctrl_state_t;

  localparam logic [1:0] PATH_CROSS = 2'b00;
  localparam logic [1:0] PATH_LOOP  = 2'b01;
  localparam logic [1:0] PATH_BCAST = 2'b10;

endpackage

// File: rtl/ring_mode_decode.sv
module ring_mode_decode
  import ring_ctrl_pkg::*;
(
  input  logic  strap_keygen,
  input  logic  strap_cu_gnd,
  output role_t role
);

  // R1: strap pair to role
  always_comb begin
    unique case ({strap_keygen, strap_cu_gnd})
      2'b10:   role = ROLE_PHANTOM;
      2'b00:   role = ROLE_CONC;
      2'b01:   role = ROLE_LOBE;
      default: role = ROLE_RINGIN;
    endcase
  end

endmodule

// File: rtl/ring_span_timer.sv
module ring_span_timer #(
  parameter int LIMIT = 868
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);

  localparam int            W    = $clog2(LIMIT + 1);
  localparam logic [W-1:0]  LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (en && cnt_q != LAST)
      cnt_q <= cnt_q + 1'b1;
  end

  // done on the LIMIT-th consecutive enabled edge
  assign done = en && (cnt_q == LAST);

  AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);                                        // R2
  AST_SPAN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));                                // R6

endmodule

// File: rtl/ring_insert_ctrl.sv
module ring_insert_ctrl
  import ring_ctrl_pkg::*;
#(
  parameter int QUAL_CYC = 868,
  parameter int ECHO_CYC = 3277
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_keygen,
  input  logic       strap_cu_gnd,
  input  logic       phan_a,
  input  logic       phan_b,
  input  logic       opt_active,
  input  logic       ins_key_seen,
  input  logic       byp_key_seen,
  input  logic       echo_seen,
  input  logic       phan_fault,
  output logic       req_ins_key,
  output logic       req_byp_key,
  output logic       phan_drive_en,
  output logic       inserted_n,
  output logic [1:0] path_sel
);

  role_t       role;
  ctrl_state_t state_q, state_d;
  logic        gen_role, phan_low;
  logic        span_en, span_clr, span_done;
  logic        echo_en, echo_done;
  logic        qual_en, gap_en;

  ring_mode_decode u_decode (
    .strap_keygen (strap_keygen),
    .strap_cu_gnd (strap_cu_gnd),
    .role         (role)
  );

  assign gen_role = (role == ROLE_PHANTOM) || (role == ROLE_RINGIN);
  assign phan_low = !phan_a && !phan_b;

  // one timer serves qualification (idle) and the activity gap (ring-in insert)
  assign qual_en  = gen_role && (state_q == ST_IDLE) && phan_low &&
                    ((role == ROLE_PHANTOM) || opt_active);
  assign gap_en   = (role == ROLE_RINGIN) && (state_q == ST_INS) && !opt_active;
  assign span_en  = qual_en || gap_en;
  assign span_clr = !span_en || (state_d != state_q);

  ring_span_timer #(.LIMIT(QUAL_CYC)) u_span (
    .clk  (clk),
    .rst  (rst),
    .clr  (span_clr),
    .en   (span_en),
    .done (span_done)
  );

  assign echo_en = (state_q == ST_ECHO);

  ring_span_timer #(.LIMIT(ECHO_CYC)) u_echo (
    .clk  (clk),
    .rst  (rst),
    .clr  (!echo_en),
    .en   (echo_en),
    .done (echo_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (gen_role) begin
          if (span_done) state_d = ST_ECHO;
        end else if (ins_key_seen) begin
          state_d = ST_INS;
        end
      end
      ST_ECHO: begin
        if (!gen_role)      state_d = ST_IDLE;
        else if (echo_seen) state_d = ST_INS;
        else if (echo_done) state_d = ST_IDLE;
      end
      ST_INS: begin
        if (gen_role) begin
          if (!phan_low || ((role == ROLE_RINGIN) && span_done))
            state_d = ST_IDLE;
        end else if (byp_key_seen) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      req_ins_key   <= 1'b0;
      req_byp_key   <= 1'b0;
      phan_drive_en <= 1'b0;
      inserted_n    <= 1'b1;
      path_sel      <= PATH_CROSS;
    end else begin
      state_q       <= state_d;
      req_ins_key   <= (state_q == ST_IDLE) && (state_d == ST_ECHO);
      req_byp_key   <= gen_role && (state_q == ST_INS) && (state_d == ST_IDLE);
      phan_drive_en <= (role == ROLE_CONC) && (state_d == ST_INS);
      inserted_n    <= !((state_d == ST_INS) && !((role == ROLE_CONC) && phan_fault));
      unique case (role)
        ROLE_LOBE:   path_sel <= (state_d == ST_INS) ? PATH_CROSS : PATH_LOOP;
        ROLE_RINGIN: path_sel <= (state_d == ST_INS) ? PATH_CROSS : PATH_BCAST;
        default:     path_sel <= PATH_CROSS;
      endcase
    end
  end

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
    !(req_ins_key && req_byp_key));                                       // R5
  AST_REQ_GEN_ONLY: assert property (@(posedge clk) disable iff (rst)
    req_ins_key |-> $past(strap_keygen));                                 // R12
  AST_EXIT_BYPASS_KEY: assert property (@(posedge clk) disable iff (rst)
    ($past(strap_keygen) && $rose(inserted_n)) |-> req_byp_key);          // R5
  AST_DRIVE_FOR_INDICATOR: assert property (@(posedge clk) disable iff (rst)
    ($past(!strap_keygen && !strap_cu_gnd) && !inserted_n) |-> phan_drive_en); // R8
  AST_FIXED_CROSS: assert property (@(posedge clk) disable iff (rst)
    !strap_cu_gnd |=> (path_sel == PATH_CROSS));                          // R10

endmodule

// File: tb/ring_insert_ctrl_test.sv
`timescale 1ns/1ps
module ring_insert_ctrl_test;

  localparam int QUAL = 12;
  localparam int ECHO = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kg = 1'b1, cg = 1'b0;
  logic pa = 1'b1, pb = 1'b1, opt = 1'b0;
  logic ik = 1'b0, bk = 1'b0, ek = 1'b0, flt = 1'b0;
  logic req_i, req_b, drv, ins_n;
  logic [1:0] path;

  always #2.5 clk = ~clk;

  ring_insert_ctrl #(.QUAL_CYC(QUAL), .ECHO_CYC(ECHO)) uut (
    .clk(clk), .rst(rst), .strap_keygen(kg), .strap_cu_gnd(cg),
    .phan_a(pa), .phan_b(pb), .opt_active(opt),
    .ins_key_seen(ik), .byp_key_seen(bk), .echo_seen(ek), .phan_fault(flt),
    .req_ins_key(req_i), .req_byp_key(req_b), .phan_drive_en(drv),
    .inserted_n(ins_n), .path_sel(path)
  );

  typedef struct {
    int         rq;
    logic       ins_n;
    logic       drv;
    logic [1:0] path;
    int         n_ins;
    int         n_byp;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, errors = 0;
  int   n_ins = 0, n_byp = 0;
  bit   finished = 0;

  // request pulse counters
  always @(negedge clk) begin
    if (rst) begin
      n_ins = 0;
      n_byp = 0;
    end else begin
      if (req_i) n_ins++;
      if (req_b) n_byp++;
    end
  end

  // monitor: pops expectations and compares
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (ins_n !== e.ins_n || drv !== e.drv || path !== e.path ||
            n_ins != e.n_ins || n_byp != e.n_byp) begin
          errors++;
          $display("FAIL R%0d: actual ins_n=%b drv=%b path=%0d reqI=%0d reqB=%0d expected ins_n=%b drv=%b path=%0d reqI=%0d reqB=%0d",
                   e.rq, ins_n, drv, path, n_ins, n_byp,
                   e.ins_n, e.drv, e.path, e.n_ins, e.n_byp);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(input int rq, input logic i_n, input logic d,
                           input logic [1:0] p, input int ei, input int eb);
    exp_t e;
    e.rq = rq; e.ins_n = i_n; e.drv = d; e.path = p; e.n_ins = ei; e.n_byp = eb;
    exp_q.push_back(e);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    cyc(1);
    s = 1'b0;
  endtask

  task automatic do_reset(input logic k, input logic c);
    @(negedge clk);
    rst = 1'b1; kg = k; cg = c;
    pa = 1'b1; pb = 1'b1; opt = 1'b0; ik = 1'b0; bk = 1'b0; ek = 1'b0; flt = 1'b0;
    cyc(3);
    expect_st(11, 1'b1, 1'b0, 2'b00, 0, 0);          // R11 reset state
    cyc(1);
    rst = 1'b0;
  endtask

  initial begin
    // ---------------- phantom-triggered role ----------------
    do_reset(1'b1, 1'b0);
    cyc(1);
    expect_st(1, 1'b1, 1'b0, 2'b00, 0, 0);           // R1 / R10 cross path
    pulse(ik); pulse(ek); cyc(1);
    expect_st(12, 1'b1, 1'b0, 2'b00, 0, 0);          // R12 recognitions ignored
    pa = 0; pb = 0;
    cyc(QUAL - 2);
    pb = 1; cyc(1); pb = 0;
    cyc(QUAL - 1);
    expect_st(2, 1'b1, 1'b0, 2'b00, 0, 0);           // R2 restart, not yet
    cyc(1);
    expect_st(2, 1'b1, 1'b0, 2'b00, 1, 0);           // R2 request on QUAL-th edge
    pa = 1; cyc(3);
    expect_st(3, 1'b1, 1'b0, 2'b00, 1, 0);           // R3 phantom ignored in wait
    pa = 0; cyc(2);
    pulse(ek);
    expect_st(3, 1'b0, 1'b0, 2'b00, 1, 0);           // R3 echo inserts
    pb = 1; cyc(1);
    expect_st(5, 1'b1, 1'b0, 2'b00, 1, 1);           // R5 exit with bypass key
    cyc(QUAL + 2);
    expect_st(2, 1'b1, 1'b0, 2'b00, 1, 1);           // R2 no request while high
    pb = 0; cyc(QUAL);
    expect_st(2, 1'b1, 1'b0, 2'b00, 2, 1);           // R2 second request
    cyc(ECHO);
    pulse(ek);
    expect_st(4, 1'b1, 1'b0, 2'b00, 2, 1);           // R4 late echo ignored
    cyc(QUAL - 2);
    expect_st(4, 1'b1, 1'b0, 2'b00, 2, 1);           // R4 qualification restarted
    cyc(1);
    expect_st(4, 1'b1, 1'b0, 2'b00, 3, 1);           // R4 request after timeout

    // ---------------- ring-in role ----------------
    do_reset(1'b1, 1'b1);
    pa = 0; pb = 0;
    cyc(1);
    expect_st(1, 1'b1, 1'b0, 2'b10, 0, 0);           // R1 / R10 broadcast bypass
    cyc(QUAL + 2);
    expect_st(6, 1'b1, 1'b0, 2'b10, 0, 0);           // R6 no activity, no request
    opt = 1; cyc(QUAL - 1);
    opt = 0; cyc(1);
    opt = 1; cyc(QUAL - 1);
    expect_st(6, 1'b1, 1'b0, 2'b10, 0, 0);           // R6 restart after gap
    cyc(1);
    expect_st(6, 1'b1, 1'b0, 2'b10, 1, 0);           // R6 request
    pa = 1; cyc(2); pa = 0;
    pulse(ek);
    expect_st(3, 1'b0, 1'b0, 2'b00, 1, 0);           // R3 / R10 insert cross
    opt = 0; cyc(QUAL - 1);
    opt = 1; cyc(3);
    expect_st(7, 1'b0, 1'b0, 2'b00, 1, 0);           // R7 short gap keeps insert
    opt = 0; cyc(QUAL - 1);
    expect_st(7, 1'b0, 1'b0, 2'b00, 1, 0);           // R7 not yet
    cyc(1);
    expect_st(7, 1'b1, 1'b0, 2'b10, 1, 1);           // R7 inactivity exit
    opt = 1; cyc(QUAL);
    expect_st(6, 1'b1, 1'b0, 2'b10, 2, 1);           // R6 requalify
    pulse(ek);
    pb = 1; cyc(1);
    expect_st(7, 1'b1, 1'b0, 2'b10, 2, 2);           // R7 phantom exit
    pb = 0;

    // ---------------- concentrator role ----------------
    do_reset(1'b0, 1'b0);
    pa = 0; pb = 0; opt = 1;
    cyc(QUAL + 2);
    expect_st(12, 1'b1, 1'b0, 2'b00, 0, 0);          // R12 no key requests
    pulse(ek); pulse(bk);
    expect_st(12, 1'b1, 1'b0, 2'b00, 0, 0);          // R12 echo/bypass ignored
    pulse(ik);
    expect_st(8, 1'b0, 1'b1, 2'b00, 0, 0);           // R8 insert, drive on
    flt = 1; cyc(1);
    expect_st(8, 1'b1, 1'b1, 2'b00, 0, 0);           // R8 fault raises indicator
    flt = 0; cyc(1);
    expect_st(8, 1'b0, 1'b1, 2'b00, 0, 0);           // R8 fault cleared
    pulse(bk);
    expect_st(8, 1'b1, 1'b0, 2'b00, 0, 0);           // R8 drive removed

    // ---------------- lobe role ----------------
    do_reset(1'b0, 1'b1);
    cyc(1);
    expect_st(1, 1'b1, 1'b0, 2'b01, 0, 0);           // R1 / R10 loop bypass
    pulse(ik);
    expect_st(9, 1'b0, 1'b0, 2'b00, 0, 0);           // R9 insert
    pulse(ik);
    expect_st(9, 1'b0, 1'b0, 2'b00, 0, 0);           // R9 repeat key no effect
    pulse(bk);
    expect_st(9, 1'b1, 1'b0, 2'b01, 0, 0);           // R9 bypass

    cyc(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule